// File: doc/BRIEF.md
# Transmit Frame Preamble and Header Generator

This block builds the bit sequence that leads each outgoing packet on a spread-spectrum transmit path. When a start request arrives while it is idle, it latches its configuration. It then sends a run of synchronization ones of programmable length, followed by a header whose size depends on a two-bit mode, and a CRC-16 over that header. After that it hands the payload stream through, one bit per accepted handshake, until the configured number of payload bits has gone out.

Alongside every bit it drives a modulation flag. The flag stays at differential BPSK for everything the block generates. It switches to the configured payload modulation on exactly the first payload bit, and drops back when the frame ends. A bypass setting skips the internal preamble and header so that an external source can supply them inside the payload stream. Scrambling, spreading and modulation happen downstream.

Top module: `framer_top`

## Requirements
- R1: While in reset and whenever no frame is in progress, bit_valid_o, pay_ready_o and qpsk_o are all 0; the cycle after rst is released the block is idle.
- R2: A start_i seen while idle makes the next cycle the first of cfg_pre_len_i preamble bits, each a 1. A length of 0 skips the preamble.
- R3: The header follows the preamble most significant bit first. Mode 0 sends a 16-bit delimiter of value 0xF3A0. Mode 1 adds the 8-bit signal field, mode 2 adds the 8-bit service field after that, and mode 3 adds the 16-bit length field last (16, 24, 32 or 48 bits).
- R4: Right after the last header bit come 16 check bits. They are the CRC over the header bits only, with generator 0x1021 (x^16+x^12+x^5+1), register preset to 0xFFFF, sent inverted with bit 15 first.
- R5: After the check bits the data phase holds pay_ready_o at 1. bit_o equals pay_bit_i and bit_valid_o equals pay_valid_i. Exactly cfg_length_i payload bits are accepted, then the block returns to idle. With a length of 0 there is no data phase.
- R6: qpsk_o is 0 during preamble, header and check bits. In the data phase it equals the cfg_qpsk_i value latched at start, from the first payload bit on. It returns to 0 once the frame ends.
- R7: With cfg_bypass_i set at start, no preamble, header or check bits are produced. The block enters the data phase at once for cfg_length_i bits, and qpsk_o follows the latched cfg_qpsk_i throughout.
- R8: start_i and every cfg input are ignored while a frame is in progress; the whole frame uses the values sampled at its start.
- R9: Generated bits (preamble, header, check) are emitted one per clock with bit_valid_o held at 1 and no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Frame start request, taken only when idle |
| cfg_mode_i | input | 2 | Header format select |
| cfg_pre_len_i | input | PRE_W | Preamble length in bits |
| cfg_qpsk_i | input | 1 | Payload modulation: 1 selects DQPSK, 0 DBPSK |
| cfg_bypass_i | input | 1 | Skip internal preamble and header |
| cfg_signal_i | input | 8 | Signal field value |
| cfg_service_i | input | 8 | Service field value |
| cfg_length_i | input | 16 | Payload bit count, also the length field |
| pay_bit_i | input | 1 | Payload bit |
| pay_valid_i | input | 1 | Payload bit present |
| pay_ready_o | output | 1 | Block takes a payload bit this cycle |
| bit_o | output | 1 | Serial output bit |
| bit_valid_o | output | 1 | bit_o carries a frame bit |
| qpsk_o | output | 1 | Modulation flag for the current bit |

## Verification
The hardest situations to reach are a new start request with altered configuration arriving in the middle of a frame, and a payload stream that stalls right at the switchover or at its last bit. The stimulus table drives one frame that pokes start_i and scrambles every cfg input for a cycle while the frame is busy. Several frames withhold pay_valid_i in a repeating pattern, so stalls land on varied payload positions, including the first and last. The bench compares each emitted bit and flag against a model built from the requirements, and checks that the block is quiet immediately after the final payload bit.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int SFD_W   = 16;
    localparam int SIG_W   = 8;
    localparam int SVC_W   = 8;
    localparam int LEN_W   = 16;
    localparam int HDR_MAX = SFD_W + SIG_W + SVC_W + LEN_W;
    localparam int HLEN_W  = $clog2(HDR_MAX + 1);
    localparam int CRC_W   = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_CHK,
        PH_DATA
    } phase_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur, input logic din);
        logic fb;
        fb = din ^ cur[CRC_W-1];
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/framer_hdr_build.sv
module framer_hdr_build
    import framer_pkg::*;
#(
    parameter logic [SFD_W-1:0] SFD_VAL = 16'hF3A0
) (
    input  logic [1:0]         mode_i,
    input  logic [SIG_W-1:0]   sig_i,
    input  logic [SVC_W-1:0]   svc_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic [HDR_MAX-1:0] hdr_o,
    output logic [HLEN_W-1:0]  hdr_len_o
);

    always_comb begin
        unique case (mode_i)
            2'd0: begin
                hdr_o     = {SFD_VAL, {(HDR_MAX-SFD_W){1'b0}}};
                hdr_len_o = HLEN_W'(SFD_W);
            end
            2'd1: begin
                hdr_o     = {SFD_VAL, sig_i, {(HDR_MAX-SFD_W-SIG_W){1'b0}}};
                hdr_len_o = HLEN_W'(SFD_W + SIG_W);
            end
            2'd2: begin
                hdr_o     = {SFD_VAL, sig_i, svc_i, {LEN_W{1'b0}}};
                hdr_len_o = HLEN_W'(SFD_W + SIG_W + SVC_W);
            end
            default: begin
                hdr_o     = {SFD_VAL, sig_i, svc_i, len_i};
                hdr_len_o = HLEN_W'(HDR_MAX);
            end
        endcase
    end

endmodule

// File: rtl/framer_crc16.sv
module framer_crc16
    import framer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_i,
    input  logic upd_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic msb_o
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            crc_q <= CRC_SEED;
        end else if (upd_i) begin
            crc_q <= crc_step(crc_q, bit_i);
        end else if (shift_i) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
        end
    end

    assign msb_o = crc_q[CRC_W-1];

    // R4: accumulate, emit and reseed never overlap
    p_ctl_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({init_i, upd_i, shift_i}));

endmodule

// File: rtl/framer_top.sv
module framer_top
    import framer_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter logic [SFD_W-1:0] SFD_VAL = 16'hF3A0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic [PRE_W-1:0] cfg_pre_len_i,
    input  logic             cfg_qpsk_i,
    input  logic             cfg_bypass_i,
    input  logic [SIG_W-1:0] cfg_signal_i,
    input  logic [SVC_W-1:0] cfg_service_i,
    input  logic [LEN_W-1:0] cfg_length_i,
    input  logic             pay_bit_i,
    input  logic             pay_valid_i,
    output logic             pay_ready_o,
    output logic             bit_o,
    output logic             bit_valid_o,
    output logic             qpsk_o
);

    localparam int CNT_W = (PRE_W > LEN_W) ? PRE_W : LEN_W;

    phase_t             phase;
    logic [CNT_W-1:0]   cnt;
    logic [HDR_MAX-1:0] hsh;
    logic [HLEN_W-1:0]  hlen_q;
    logic [LEN_W-1:0]   len_q;
    logic               qpsk_q;

    logic [HDR_MAX-1:0] hdr_vec;
    logic [HLEN_W-1:0]  hdr_len;
    logic               crc_msb;
    logic               last;
    logic               take;

    framer_hdr_build #(.SFD_VAL(SFD_VAL)) hdr_i (
        .mode_i    (cfg_mode_i),
        .sig_i     (cfg_signal_i),
        .svc_i     (cfg_service_i),
        .len_i     (cfg_length_i),
        .hdr_o     (hdr_vec),
        .hdr_len_o (hdr_len)
    );

    framer_crc16 crc_i (
        .clk     (clk),
        .rst     (rst),
        .init_i  (phase == PH_IDLE),
        .upd_i   (phase == PH_HDR),
        .shift_i (phase == PH_CHK),
        .bit_i   (hsh[HDR_MAX-1]),
        .msb_o   (crc_msb)
    );

    assign last = (cnt == CNT_W'(1));
    assign take = pay_valid_i && pay_ready_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            hsh    <= '0;
            hlen_q <= '0;
            len_q  <= '0;
            qpsk_q <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        len_q  <= cfg_length_i;
                        qpsk_q <= cfg_qpsk_i;
                        hsh    <= hdr_vec;
                        hlen_q <= hdr_len;
                        if (cfg_bypass_i) begin
                            if (cfg_length_i != '0) begin
                                phase <= PH_DATA;
                                cnt   <= CNT_W'(cfg_length_i);
                            end
                        end else if (cfg_pre_len_i != '0) begin
                            phase <= PH_PRE;
                            cnt   <= CNT_W'(cfg_pre_len_i);
                        end else begin
                            phase <= PH_HDR;
                            cnt   <= CNT_W'(hdr_len);
                        end
                    end
                end
                PH_PRE: begin
                    cnt <= cnt - CNT_W'(1);
                    if (last) begin
                        phase <= PH_HDR;
                        cnt   <= CNT_W'(hlen_q);
                    end
                end
                PH_HDR: begin
                    hsh <= {hsh[HDR_MAX-2:0], 1'b0};
                    cnt <= cnt - CNT_W'(1);
                    if (last) begin
                        phase <= PH_CHK;
                        cnt   <= CNT_W'(CRC_W);
                    end
                end
                PH_CHK: begin
                    cnt <= cnt - CNT_W'(1);
                    if (last) begin
                        if (len_q == '0) begin
                            phase <= PH_IDLE;
                        end else begin
                            phase <= PH_DATA;
                            cnt   <= CNT_W'(len_q);
                        end
                    end
                end
                PH_DATA: begin
                    if (take) begin
                        cnt <= cnt - CNT_W'(1);
                        if (last) begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            PH_PRE:  begin bit_o = 1'b1;              bit_valid_o = 1'b1;        end
            PH_HDR:  begin bit_o = hsh[HDR_MAX-1];    bit_valid_o = 1'b1;        end
            PH_CHK:  begin bit_o = ~crc_msb;          bit_valid_o = 1'b1;        end
            PH_DATA: begin bit_o = pay_bit_i;         bit_valid_o = pay_valid_i; end
            default: begin bit_o = 1'b0;              bit_valid_o = 1'b0;        end
        endcase
    end

    assign pay_ready_o = (phase == PH_DATA);
    assign qpsk_o      = (phase == PH_DATA) && qpsk_q;

    // R1: idle block is silent
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!bit_valid_o && !pay_ready_o && !qpsk_o));

    // R9: generated bits advance one per cycle
    p_frame_step_r9: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_PRE || phase == PH_HDR || phase == PH_CHK) && !last)
        |=> (phase == $past(phase) && cnt == $past(cnt) - CNT_W'(1)));

    // R4: header end leads into exactly CRC_W check bits
    p_hdr_to_chk_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HDR && last) |=> (phase == PH_CHK && cnt == CNT_W'(CRC_W)));

    // R5: a stalled payload stream holds the data phase
    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && !take) |=> (phase == PH_DATA && $stable(cnt)));

    // R6: the DQPSK flag only rides on payload slots and never changes within them
    p_qpsk_data_r6: assert property (@(posedge clk) disable iff (rst)
        qpsk_o |-> pay_ready_o);
    p_qpsk_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (pay_ready_o && $past(pay_ready_o)) |-> $stable(qpsk_o));

    // R8: a start request mid-frame does not end or restart the frame
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && start_i && !last) |=> (phase != PH_IDLE));

endmodule

// File: tb/framer_top_tb_top.sv
module framer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  cfg_mode_i = '0;
    logic [7:0]  cfg_pre_len_i = '0;
    logic        cfg_qpsk_i = 1'b0;
    logic        cfg_bypass_i = 1'b0;
    logic [7:0]  cfg_signal_i = '0;
    logic [7:0]  cfg_service_i = '0;
    logic [15:0] cfg_length_i = '0;
    logic        pay_bit_i = 1'b0;
    logic        pay_valid_i = 1'b0;
    logic        pay_ready_o;
    logic        bit_o;
    logic        bit_valid_o;
    logic        qpsk_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    framer_top dut_i (
        .clk(clk), .rst(rst), .start_i(start_i),
        .cfg_mode_i(cfg_mode_i), .cfg_pre_len_i(cfg_pre_len_i),
        .cfg_qpsk_i(cfg_qpsk_i), .cfg_bypass_i(cfg_bypass_i),
        .cfg_signal_i(cfg_signal_i), .cfg_service_i(cfg_service_i),
        .cfg_length_i(cfg_length_i), .pay_bit_i(pay_bit_i),
        .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o),
        .bit_o(bit_o), .bit_valid_o(bit_valid_o), .qpsk_o(qpsk_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  pre;
        logic        q;
        logic        byp;
        logic [15:0] len;
        logic [7:0]  sig;
        logic [7:0]  svc;
        logic        gap;
        logic        poke;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd8,   1'b1, 1'b0, 16'd12, 8'hA5, 8'h3C, 1'b0, 1'b0},
        '{2'd1, 8'd16,  1'b0, 1'b0, 16'd8,  8'h5A, 8'h00, 1'b1, 1'b0},
        '{2'd2, 8'd4,   1'b1, 1'b0, 16'd20, 8'h0F, 8'hC3, 1'b1, 1'b1},
        '{2'd3, 8'd10,  1'b1, 1'b0, 16'd24, 8'h81, 8'h7E, 1'b0, 1'b0},
        '{2'd3, 8'd0,   1'b1, 1'b0, 16'd5,  8'h12, 8'h34, 1'b0, 1'b0},
        '{2'd2, 8'd3,   1'b1, 1'b0, 16'd0,  8'hFF, 8'h01, 1'b0, 1'b0},
        '{2'd3, 8'd7,   1'b1, 1'b1, 16'd9,  8'h99, 8'h66, 1'b1, 1'b0},
        '{2'd3, 8'd255, 1'b0, 1'b0, 16'd3,  8'h42, 8'h24, 1'b1, 1'b0}
    };

    bit exp_b [0:511];
    bit exp_q [0:511];
    bit pay   [0:127];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic apply_cfg(input vec_t v);
        cfg_mode_i    = v.mode;
        cfg_pre_len_i = v.pre;
        cfg_qpsk_i    = v.q;
        cfg_bypass_i  = v.byp;
        cfg_signal_i  = v.sig;
        cfg_service_i = v.svc;
        cfg_length_i  = v.len;
    endtask

    task automatic run_frame(input vec_t v, input int idx);
        int n = 0;
        int npre = 0;
        int nhdr = 0;
        int nfr = 0;
        int got = 0;
        int pk = 0;
        int cyc = 0;
        int mism = 0;
        logic [47:0] hv;
        logic [15:0] crc = 16'hFFFF;
        string tag;
        for (int k = 0; k < int'(v.len); k++) pay[k] = (((k * 5) + (idx * 3)) % 7) < 3;
        if (!v.byp) begin
            for (int k = 0; k < int'(v.pre); k++) begin exp_b[n] = 1'b1; exp_q[n] = 1'b0; n++; end
            npre = n;
            case (v.mode)
                2'd0: begin hv = {16'hF3A0, 32'h0};                 nhdr = 16; end
                2'd1: begin hv = {16'hF3A0, v.sig, 24'h0};          nhdr = 24; end
                2'd2: begin hv = {16'hF3A0, v.sig, v.svc, 16'h0};   nhdr = 32; end
                default: begin hv = {16'hF3A0, v.sig, v.svc, v.len}; nhdr = 48; end
            endcase
            for (int k = 0; k < nhdr; k++) begin
                bit b = hv[47-k];
                bit fb = b ^ crc[15];
                exp_b[n] = b; exp_q[n] = 1'b0; n++;
                crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
            for (int k = 0; k < 16; k++) begin exp_b[n] = ~crc[15-k]; exp_q[n] = 1'b0; n++; end
        end
        nfr = n;
        for (int k = 0; k < int'(v.len); k++) begin exp_b[n] = pay[k]; exp_q[n] = v.q; n++; end

        @(negedge clk);
        apply_cfg(v);
        start_i = 1'b1;
        pay_valid_i = 1'b0;
        @(negedge clk);
        while (got < n && cyc < 1500) begin
            apply_cfg(v);
            start_i = 1'b0;
            if (v.poke && cyc == 5) begin
                start_i       = 1'b1;
                cfg_mode_i    = ~v.mode;
                cfg_qpsk_i    = ~v.q;
                cfg_bypass_i  = ~v.byp;
                cfg_length_i  = v.len + 16'd3;
                cfg_signal_i  = ~v.sig;
                cfg_pre_len_i = v.pre + 8'd9;
            end
            pay_valid_i = v.gap ? ((cyc % 3) != 2) : 1'b1;
            pay_bit_i   = pay[pk];
            #1;
            // ready must be high exactly in the payload region
            chk(pay_ready_o == (got >= nfr), "R5", pay_ready_o, (got >= nfr));
            if (got < nfr) chk(bit_valid_o, "R9", bit_valid_o, 1);
            if (bit_valid_o) begin
                if (v.byp)                   tag = "R7";
                else if (got < npre)         tag = "R2";
                else if (got < npre + nhdr)  tag = "R3";
                else if (got < nfr)          tag = "R4";
                else                         tag = "R5";
                if (bit_o !== exp_b[got]) mism++;
                chk(bit_o === exp_b[got], tag, bit_o, exp_b[got]);
                if (qpsk_o !== exp_q[got]) mism++;
                chk(qpsk_o === exp_q[got], "R6", qpsk_o, exp_q[got]);
                got++;
            end
            if (pay_ready_o && pay_valid_i) pk++;
            cyc++;
            @(negedge clk);
        end
        chk(got == n, "R5", got, n);
        chk(pk == int'(v.len), "R5", pk, v.len);
        if (v.poke) chk(mism == 0, "R8", mism, 0);
        apply_cfg(v);
        start_i     = 1'b0;
        pay_valid_i = 1'b1;
        #1;
        chk(!bit_valid_o && !pay_ready_o, "R5", bit_valid_o, 0);
        chk(!qpsk_o, "R6", qpsk_o, 0);
        pay_valid_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R1: outputs quiet in reset
        chk(!bit_valid_o && !pay_ready_o && !qpsk_o, "R1", {bit_valid_o, pay_ready_o, qpsk_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!bit_valid_o && !pay_ready_o && !qpsk_o, "R1", {bit_valid_o, pay_ready_o, qpsk_o}, 0);

        for (int i = 0; i < NV; i++) run_frame(VECS[i], i);

        // R1: reset in the middle of a frame returns the block to idle
        @(negedge clk);
        apply_cfg(VECS[3]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
        #1;
        chk(bit_valid_o, "R2", bit_valid_o, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pay_valid_i = 1'b1;
        #1;
        chk(!bit_valid_o && !pay_ready_o && !qpsk_o, "R1", {bit_valid_o, pay_ready_o, qpsk_o}, 0);
        pay_valid_i = 1'b0;
        run_frame(VECS[0], 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule